// File: doc/BRIEF.md
# Tiled Framebuffer Address Generator

This block turns a pixel coordinate of a 32-bit-per-pixel image into the byte offset of that pixel in memory. A mode input selects one of two layouts. The first is a plain raster layout with a programmable byte pitch. The second is a hierarchical tiled layout. In that layout, 4x4-pixel micro-tiles of 64 bytes form 16x16-pixel subtiles of 1 KB, and subtiles form 32x32-pixel tiles of 4 KB. Rows of tiles are walked in a serpentine: even tile rows run left to right and odd tile rows run right to left. The order of the four subtiles inside a tile also depends on the parity of the tile row.

Requests enter on a valid/ready stream that carries the coordinate, the image width in pixels, the pitch and the mode. Results leave on a second valid/ready stream through a one-entry output register, one cycle after acceptance. The input side stays ready whenever the output register is empty or is being drained in the same cycle. Back-pressure from the output stream therefore stalls the input within the same cycle, and the block loses no result.

Top module: `tiled_addr_gen`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A request is accepted on a clock edge where in_valid and in_ready are both 1. Its result appears on out_valid in the following cycle. While out_ready stays 1, one request is accepted every cycle with no stall.
- R3: While out_valid is 1 and out_ready is 0, out_offset and out_err hold their values, out_valid stays 1, and in_ready is 0.
- R4: When in_mode is 0 (raster), the offset is in_y*in_pitch + in_x*4, where in_pitch is a 16-bit byte count.
- R5: When in_mode is 1 (tiled), the offset within a subtile is (y[3:2]*4 + x[3:2])*64 + (y[1:0]*4 + x[1:0])*4. Micro-tiles and the pixels inside them are stored in raster order.
- R6: Within a tile, the half with y[4]=0 is the bottom half and the half with x[4]=0 is the left half. In an even tile row (y[5]=0), the subtile slots are bottom-left=0, top-left=1, top-right=2 and bottom-right=3. Each slot adds slot*1024.
- R7: In an odd tile row (y[5]=1), the subtile slots are top-right=0, bottom-right=1, bottom-left=2 and top-left=3.
- R8: The tile base is (tile_row*tiles_per_row + stored_col)*4096, where tile_row=y>>5 and col=x>>5. stored_col equals col in even tile rows and tiles_per_row-1-col in odd tile rows.
- R9: tiles_per_row is (in_width+31)>>5. An image width that is not a multiple of 32 rounds up to a whole tile.
- R10: Mode values 2 and 3 give out_err=1 and an offset of 0. Modes 0 and 1 give out_err=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block can accept a request |
| in_x | input | COORD_W (11) | Pixel column |
| in_y | input | COORD_W (11) | Pixel row, 0 at the lowest address |
| in_width | input | COORD_W+1 (12) | Image width in pixels |
| in_pitch | input | PITCH_W (16) | Raster row pitch in bytes |
| in_mode | input | 2 | Layout select: 0 raster, 1 tiled, others invalid |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_offset | output | OFF_W (32) | Byte offset of the pixel |
| out_err | output | 1 | Invalid mode was requested |

## Verification
Every result reaches the ports in the cycle after its request is accepted. A fault in the tiled path therefore shows on the very next out_valid beat, and its size points to where the fault is. A wrong subtile slot moves the offset by a multiple of 1024. A wrong serpentine column or tiles-per-row value moves it by a multiple of 4096. A wrong micro-tile or pixel index moves it by less than 1024. The bench puts coordinates on both sides of each 4-, 16- and 32-pixel boundary, in even and odd tile rows, with widths that round up. It applies random back-pressure, so a result lost or overwritten in the output register shows as a mismatch or a count error in the scoreboard within one beat.

// File: rtl/tag_pkg.sv
package tag_pkg;
  typedef enum logic [1:0] {
    LAYOUT_RASTER = 2'd0,
    LAYOUT_TILED  = 2'd1
  } layout_e;

  localparam int MICRO_SHIFT   = 6;   // 64-byte micro-tile
  localparam int SUBTILE_SHIFT = 10;  // 1 KB subtile
  localparam int TILE_SHIFT    = 12;  // 4 KB tile
  localparam int TILE_PIX_LOG2 = 5;   // 32 pixels per tile edge
endpackage

// File: rtl/subtile_slot.sv
module subtile_slot (
  input  logic       odd_row,
  input  logic       top_half,
  input  logic       right_half,
  output logic [1:0] slot
);
  always_comb begin
    unique case ({odd_row, top_half, right_half})
      3'b0_0_0: slot = 2'd0; // even: bottom-left
      3'b0_1_0: slot = 2'd1; // even: top-left
      3'b0_1_1: slot = 2'd2; // even: top-right
      3'b0_0_1: slot = 2'd3; // even: bottom-right
      3'b1_1_1: slot = 2'd0; // odd: top-right
      3'b1_0_1: slot = 2'd1; // odd: bottom-right
      3'b1_0_0: slot = 2'd2; // odd: bottom-left
      default:  slot = 2'd3; // odd: top-left
    endcase
  end
endmodule

// File: rtl/raster_calc.sv
module raster_calc #(
  parameter int COORD_W = 11,
  parameter int PITCH_W = 16,
  parameter int OFF_W   = 32
) (
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [PITCH_W-1:0] pitch,
  output logic [OFF_W-1:0]   offset
);
  logic [OFF_W-1:0] row_bytes;
  logic [OFF_W-1:0] col_bytes;

  always_comb begin
    row_bytes = OFF_W'(y) * OFF_W'(pitch);
    col_bytes = OFF_W'(x) << 2;
    offset    = row_bytes + col_bytes;
  end
endmodule

// File: rtl/tiled_calc.sv
module tiled_calc
  import tag_pkg::*;
#(
  parameter int COORD_W = 11,
  parameter int OFF_W   = 32
) (
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [COORD_W:0]   width,
  output logic [OFF_W-1:0]   offset
);
  logic [OFF_W-1:0] tile_row, tile_col, tiles_per_row, stored_col;
  logic [OFF_W-1:0] tile_base, sub_part, micro_part, pix_part;
  logic [1:0]       slot;
  logic             odd_row;
  logic [3:0]       micro_idx;
  logic [3:0]       pix_idx;

  assign odd_row = y[TILE_PIX_LOG2];

  subtile_slot u_slot (
    .odd_row    (odd_row),
    .top_half   (y[4]),
    .right_half (x[4]),
    .slot       (slot)
  );

  always_comb begin
    tile_row      = OFF_W'(y >> TILE_PIX_LOG2);
    tile_col      = OFF_W'(x >> TILE_PIX_LOG2);
    tiles_per_row = (OFF_W'(width) + OFF_W'(31)) >> TILE_PIX_LOG2;
    stored_col    = odd_row ? (tiles_per_row - OFF_W'(1) - tile_col) : tile_col;
    tile_base     = (tile_row * tiles_per_row + stored_col) << TILE_SHIFT;
    sub_part      = OFF_W'(slot) << SUBTILE_SHIFT;
    micro_idx     = {y[3:2], x[3:2]};
    micro_part    = OFF_W'(micro_idx) << MICRO_SHIFT;
    pix_idx       = {y[1:0], x[1:0]};
    pix_part      = OFF_W'(pix_idx) << 2;
    offset        = tile_base + sub_part + micro_part + pix_part;
  end
endmodule

// File: rtl/addr_out_stage.sv
module addr_out_stage #(
  parameter int OFF_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OFF_W-1:0] next_offset,
  input  logic             next_err,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OFF_W-1:0] out_offset,
  output logic             out_err
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_offset <= '0;
      out_err    <= 1'b0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_offset <= next_offset;
      out_err    <= next_err;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R3: a stalled result is held unchanged
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_offset) && $stable(out_err)));

  // R2: an accepted request yields a result on the next cycle
  a_r2_result_next: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R10: an error result carries a zero offset
  a_r10_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_offset == '0));
endmodule

// File: rtl/tiled_addr_gen.sv
module tiled_addr_gen
  import tag_pkg::*;
#(
  parameter int COORD_W = 11,
  parameter int PITCH_W = 16,
  parameter int OFF_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  input  logic [COORD_W:0]   in_width,
  input  logic [PITCH_W-1:0] in_pitch,
  input  logic [1:0]         in_mode,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [OFF_W-1:0]   out_offset,
  output logic               out_err
);
  logic [OFF_W-1:0] raster_off, tiled_off, sel_off;
  logic             sel_err;

  raster_calc #(.COORD_W(COORD_W), .PITCH_W(PITCH_W), .OFF_W(OFF_W)) u_raster (
    .x(in_x), .y(in_y), .pitch(in_pitch), .offset(raster_off)
  );

  tiled_calc #(.COORD_W(COORD_W), .OFF_W(OFF_W)) u_tiled (
    .x(in_x), .y(in_y), .width(in_width), .offset(tiled_off)
  );

  always_comb begin
    sel_err = 1'b0;
    unique case (in_mode)
      LAYOUT_RASTER: sel_off = raster_off;
      LAYOUT_TILED:  sel_off = tiled_off;
      default: begin
        sel_off = '0;
        sel_err = 1'b1;
      end
    endcase
  end

  addr_out_stage #(.OFF_W(OFF_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .next_offset(sel_off), .next_err(sel_err),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_offset(out_offset), .out_err(out_err)
  );

  // R10: a supported mode never raises the error flag
  a_r10_good_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_mode[1] == 1'b0)) |=> !out_err);
endmodule

// File: tb/tiled_addr_gen_test.sv
module tiled_addr_gen_test;
  localparam int CW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [CW-1:0] in_x = '0, in_y = '0;
  logic [CW:0]   in_width = '0;
  logic [15:0]   in_pitch = '0;
  logic [1:0]    in_mode = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [31:0]   out_offset;
  logic          out_err;

  int tests = 0, fails = 0, stalls = 0;
  bit bp = 1'b0;
  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk; // 50 MHz

  tiled_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_width(in_width), .in_pitch(in_pitch),
    .in_mode(in_mode), .out_valid(out_valid), .out_ready(out_ready),
    .out_offset(out_offset), .out_err(out_err)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_off(int x, int y, int w, int p, int mode);
    int tpr, tr, tc, sc, slot, u, px;
    bit top, right;
    if (mode == 0) return y * p + x * 4;
    if (mode != 1) return 0;
    tpr = (w + 31) / 32;
    tr = y / 32; tc = x / 32;
    sc = (tr % 2 == 1) ? (tpr - 1 - tc) : tc;
    top = (y % 32) >= 16; right = (x % 32) >= 16;
    if (tr % 2 == 0) slot = right ? (top ? 2 : 3) : (top ? 1 : 0);
    else             slot = right ? (top ? 0 : 1) : (top ? 3 : 2);
    u  = ((y % 16) / 4) * 4 + (x % 16) / 4;
    px = (y % 4) * 4 + (x % 4);
    return (tr * tpr + sc) * 4096 + slot * 1024 + u * 64 + px * 4;
  endfunction

  task automatic send(int x, int y, int w, int p, int mode, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_x = CW'(x); in_y = CW'(y); in_width = (CW+1)'(w);
    in_pitch = 16'(p); in_mode = 2'(mode);
    #1;
    while (!in_ready) begin
      stalls++;
      @(negedge clk); #1;
    end
    exp_q.push_back({(mode > 1) ? 1'b1 : 1'b0, 32'(ref_off(x, y, w, p, mode))});
    tag_q.push_back(tag);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // back-pressure driver
  always @(negedge clk) out_ready <= bp ? 1'($urandom % 2) : 1'b1;

  // monitor / scoreboard
  logic        hold_prev = 1'b0;
  logic [31:0] off_prev;
  logic        err_prev;
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n) begin
        if (hold_prev) begin
          check(out_valid && out_offset == off_prev && out_err == err_prev,
                "R3 hold", {out_valid, out_offset}, {1'b1, off_prev});
        end
        hold_prev = out_valid && !out_ready;
        off_prev = out_offset; err_prev = out_err;
        if (out_valid && !out_ready)
          check(!in_ready, "R3 in_ready low", in_ready, 0);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) check(1'b0, "R2 unexpected result", out_offset, 0);
          else begin
            logic [32:0] e;
            string t;
            e = exp_q.pop_front(); t = tag_q.pop_front();
            check({out_err, out_offset} == e, t, {out_err, out_offset}, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    // R2 latency
    send(3, 2, 64, 256, 0, "R4 raster single");
    @(negedge clk); #1;
    check(out_valid == 1'b1, "R2 one-cycle latency", out_valid, 1);

    // R4 raster patterns
    send(0, 0, 64, 100, 0, "R4 raster origin");
    send(2047, 2047, 2048, 16'hFFFF, 0, "R4 raster max pitch");
    send(17, 9, 64, 4, 0, "R4 raster small pitch");

    // R5 micro-tile and pixel order in tile 0
    send(1, 0, 64, 0, 1, "R5 pixel x1");
    send(0, 1, 64, 0, 1, "R5 pixel y1");
    send(4, 0, 64, 0, 1, "R5 next micro-tile right");
    send(0, 4, 64, 0, 1, "R5 next micro-tile up");
    send(15, 15, 64, 0, 1, "R5 subtile last pixel");

    // R6 even-row slots
    send(0, 0, 64, 0, 1, "R6 even bottom-left slot0");
    send(0, 16, 64, 0, 1, "R6 even top-left slot1");
    send(16, 16, 64, 0, 1, "R6 even top-right slot2");
    send(16, 0, 64, 0, 1, "R6 even bottom-right slot3");

    // R7 odd-row slots
    send(16, 48, 64, 0, 1, "R7 odd top-right slot0");
    send(16, 32, 64, 0, 1, "R7 odd bottom-right slot1");
    send(0, 32, 64, 0, 1, "R7 odd bottom-left slot2");
    send(0, 48, 64, 0, 1, "R7 odd top-left slot3");

    // R8 serpentine and R9 rounding
    send(31, 31, 100, 0, 1, "R8 even last col tile0");
    send(32, 31, 100, 0, 1, "R8 even tile1");
    send(96, 32, 100, 0, 1, "R8 odd col3 stored first");
    send(0, 32, 100, 0, 1, "R8 odd col0 stored last");
    send(40, 95, 96, 0, 1, "R9 width 96 three tiles");
    send(0, 33, 1, 0, 1, "R9 width 1 one tile");
    send(64, 64, 65, 0, 1, "R9 width 65 rounds up");

    // R10 mode errors
    send(5, 5, 64, 64, 2, "R10 mode2 error");
    send(5, 5, 64, 64, 3, "R10 mode3 error");
    send(5, 5, 64, 64, 1, "R10 tiled after error");

    // R2 throughput burst
    repeat (4) @(negedge clk);
    stalls = 0;
    for (int i = 0; i < 20; i++) send(i * 7, i * 3, 256, 1024, i % 2, "R2 burst");
    check(stalls == 0, "R2 no stall without back-pressure", stalls, 0);

    // random with back-pressure
    bp = 1'b1;
    for (int i = 0; i < 400; i++) begin
      int w, x, y, m;
      w = 1 + int'($urandom % 2047);
      x = int'($urandom % w);
      y = int'($urandom % 2048);
      m = int'($urandom % 4);
      send(x, y, w, int'($urandom % 65536), m, "R8 random scoreboard");
    end
    bp = 1'b0;
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R2 all results delivered", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule